// File: doc/BRIEF.md
# Multi-Mode Configurable-Length Timer Counter

This block is a free-running timer counter on a single system clock. A one-cycle enable input, `tick_i`, stands in for the selected timer clock source. A prescaler divides this enable by 1, 2, 4 or 8, and each divided tick moves the count by one. The count width is chosen at run time: 8, 10, 12 or 16 bits. Four operating modes are available. The first holds the count. The second counts up to a compare value and wraps to zero. The third counts up to the length maximum and wraps. The fourth counts up to the compare value and back down to zero.

Software drives the block through a simple write port. The port selects one of three fields: the control word, the count, or the compare value. The control word sets the mode, the length, the divider and the interrupt enable. It also carries a clear strobe and a write-one-to-clear bit for the overflow flag. The flag is sticky, and it drives the interrupt output when the enable is set. A compare value of zero freezes the count in the two compare-based modes. Writing a nonzero compare value after that starts the count again from zero, counting up.

Top module: `span_timer`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` and `irq_o` are 0, and the mode is stop.
- R2: In stop mode (ctrl bits [1:0] = 00), ticks do not change `count_o`.
- R3: The count moves only on a divided tick. The ctrl field [5:4] holds a code d. With code d, one count step happens every 2^d accepted `tick_i` cycles, and cycles without `tick_i` leave the count unchanged.
- R4: In continuous mode (ctrl [1:0] = 10), the count climbs to the length maximum and then wraps to 0 on the next step, which sets the overflow flag. The length code in ctrl [3:2] picks the maximum: 00 gives 0xFF, 01 gives 0x3FF, 10 gives 0xFFF and 11 gives 0xFFFF.
- R5: A count write (`wr_addr_i` = 1) is visible on `count_o` in the cycle after the write. Bits above the selected length read as zero.
- R6: In up mode (ctrl [1:0] = 01), the count runs 0..C, where C is the compare value, written at `wr_addr_i` = 2. The step after C returns the count to 0 and sets the overflow flag.
- R7: In up/down mode (ctrl [1:0] = 11), the count runs 0..C and then C-1..0, and repeats. The step that reaches 0 while counting down sets the flag. No other step in this mode sets it.
- R8: In up and up/down modes, a compare value of 0 freezes the count. Writing a nonzero compare value while the stored value is 0 sets the count to 0 and the direction to up.
- R9: Writing ctrl with bit [6] set has three effects: the count goes to 0, the prescaler phase resets, and the up/down direction returns to up.
- R10: The overflow flag stays set until a ctrl write with bit [8] = 1 clears it. `irq_o` equals the flag ANDed with the enable in ctrl bit [7]. A write to `wr_addr_i` = 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer clock-source enable, one cycle per source edge |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write target: 0 ctrl, 1 count, 2 compare, 3 unused |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest state to reach is a combination of three conditions at once. The counter must be heading down in up/down mode, the prescaler must sit halfway through a divide-by-two period, and then a clear must arrive. The bench sets a compare value of 3 and a divide code of 1, then applies an odd number of ticks. This leaves the count falling and the prescaler mid-period. It then issues the clear. If the clear works, the first following tick must not move the count, and the second tick must raise it to 1. This shows that both the prescaler phase and the direction were reset. A second sequence checks the compare-zero freeze and restart in the middle of a falling phase.

// File: rtl/span_timer_pkg.sv
package span_timer_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_CMP   = 2'd2,
    ADDR_NONE  = 2'd3
  } addr_e;

  // ctrl word bit positions
  localparam int unsigned CTL_MODE_LO = 0;
  localparam int unsigned CTL_LEN_LO  = 2;
  localparam int unsigned CTL_DIV_LO  = 4;
  localparam int unsigned CTL_CLR     = 6;
  localparam int unsigned CTL_IE      = 7;
  localparam int unsigned CTL_FCLR    = 8;

  function automatic int unsigned len_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/span_prescaler.sv
module span_prescaler #(
  parameter int unsigned DIV_W = 2,
  localparam int unsigned PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;
  logic             last;

  assign mask   = (PRE_W'(1) << div_i) - PRE_W'(1);
  assign last   = (pcnt_q >= mask);
  assign step_o = tick_i && en_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (clr_i)           pcnt_q <= '0;
    else if (tick_i && en_i)  pcnt_q <= last ? '0 : pcnt_q + PRE_W'(1);
  end

  a_r3_phase_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !clr_i && !step_o) |=> pcnt_q == $past(pcnt_q) + PRE_W'(1));

  a_r9_phase_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pcnt_q == '0);
endmodule

// File: rtl/span_count_core.sv
module span_count_core
  import span_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [1:0]       len_i,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, cmp_q, cmp_eff, lmax;
  logic [CNT_W:0]   one_sh;
  logic             dir_q, dir_n;  // 1: counting down
  logic             wrap, restart, cmp_mode;

  assign one_sh  = (CNT_W+1)'(1) << len_bits(len_i);
  assign lmax    = one_sh[CNT_W-1:0] - CNT_W'(1);
  assign cmp_eff = cmp_q & lmax;
  assign cmp_mode = (mode_i == MODE_UP) || (mode_i == MODE_UPDN);
  assign restart = cmp_wr_i && cmp_mode && (cmp_q == '0) && (wdata_i != '0);

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    wrap  = 1'b0;
    if (step_i) begin
      case (mode_i)
        MODE_UP: if (cmp_q != '0) begin
          if (cnt_q >= cmp_eff) begin
            cnt_n = '0;
            wrap  = 1'b1;
          end else cnt_n = cnt_q + CNT_W'(1);
        end
        MODE_CONT: begin
          if (cnt_q >= lmax) begin
            cnt_n = '0;
            wrap  = 1'b1;
          end else cnt_n = cnt_q + CNT_W'(1);
        end
        MODE_UPDN: if (cmp_q != '0) begin
          if (!dir_q) begin
            if (cnt_q >= cmp_eff) begin
              dir_n = 1'b1;
              cnt_n = (cmp_eff == '0) ? '0 : cmp_eff - CNT_W'(1);
              wrap  = (cnt_n == '0);
            end else cnt_n = cnt_q + CNT_W'(1);
          end else if (cnt_q == '0) begin
            dir_n = 1'b0;
            cnt_n = CNT_W'(1);
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
            wrap  = (cnt_q == CNT_W'(1));
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= wdata_i & lmax;
    end else if (restart) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= wdata_i;
  end

  assign count_o = cnt_q;
  assign ovf_o   = wrap && !clr_i && !load_i && !restart;

  a_r2_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !clr_i && !load_i) |=> $stable(cnt_q));

  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i && !load_i && !restart) |=> $stable(cnt_q));

  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);

  a_r8_zero_cmp_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode && cmp_q == '0 && !clr_i && !load_i && !cmp_wr_i) |=> $stable(cnt_q));

  a_r9_clear_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dir_q));
endmodule

// File: rtl/span_ovf_flag.sv
module span_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  a_r10_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/span_timer.sv
module span_timer
  import span_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             irq_o
);
  mode_e            mode_q;
  logic [1:0]       len_q;
  logic [DIV_W-1:0] div_q;
  logic             ie_q;
  logic             ctl_wr, clr_pulse, fclr_pulse, step, ovf_set;

  assign ctl_wr     = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_pulse  = ctl_wr && wr_data_i[CTL_CLR];
  assign fclr_pulse = ctl_wr && wr_data_i[CTL_FCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      len_q  <= 2'd3;
      div_q  <= '0;
      ie_q   <= 1'b0;
    end else if (ctl_wr) begin
      mode_q <= mode_e'(wr_data_i[CTL_MODE_LO +: 2]);
      len_q  <= wr_data_i[CTL_LEN_LO +: 2];
      div_q  <= wr_data_i[CTL_DIV_LO +: DIV_W];
      ie_q   <= wr_data_i[CTL_IE];
    end
  end

  span_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (mode_q != MODE_STOP),
    .clr_i  (clr_pulse),
    .div_i  (div_q),
    .step_o (step)
  );

  span_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_q),
    .len_i    (len_q),
    .step_i   (step),
    .clr_i    (clr_pulse),
    .load_i   (wr_en_i && (wr_addr_i == ADDR_COUNT)),
    .cmp_wr_i (wr_en_i && (wr_addr_i == ADDR_CMP)),
    .wdata_i  (wr_data_i),
    .count_o  (count_o),
    .ovf_o    (ovf_set)
  );

  span_ovf_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (fclr_pulse),
    .ie_i   (ie_q),
    .flag_o (ovf_o),
    .irq_o  (irq_o)
  );

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (count_o == '0 && !ovf_o));
endmodule

// File: tb/span_timer_bench.sv
module span_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count;
  logic        ovf, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  span_timer u_span_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .ovf_o(ovf), .irq_o(irq)
  );

  function automatic logic [15:0] ctl(input logic [1:0] mode, input logic [1:0] len,
                                      input logic [1:0] dv, input logic clr,
                                      input logic ie, input logic fclr);
    return {7'd0, fclr, ie, clr, dv, len, mode};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_stop;
    chk("R1 count", count, 16'd0);
    chk("R1 ovf", {15'd0, ovf}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    ticks(5);
    chk("R2 stop after reset", count, 16'd0);
    wr(2'd1, 16'h0012);
    ticks(4);
    chk("R2 stop holds loaded", count, 16'h0012);
  endtask

  task automatic t_load_mask;
    wr(2'd0, ctl(2'b00, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'hABCD); chk("R5 8-bit", count, 16'h00CD);
    wr(2'd0, ctl(2'b00, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'hABCD); chk("R5 10-bit", count, 16'h03CD);
    wr(2'd0, ctl(2'b00, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'hABCD); chk("R5 12-bit", count, 16'h0BCD);
    wr(2'd0, ctl(2'b00, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0));
    wr(2'd1, 16'hABCD); chk("R5 16-bit", count, 16'hABCD);
    wr(2'd3, 16'h1234); chk("R10 addr 3 ignored", count, 16'hABCD);
  endtask

  task automatic t_cont_lengths;
    logic [15:0] mx;
    for (int l = 0; l < 4; l++) begin
      mx = (l == 0) ? 16'h00FF : (l == 1) ? 16'h03FF : (l == 2) ? 16'h0FFF : 16'hFFFF;
      wr(2'd0, ctl(2'b10, 2'(l), 2'd0, 1'b1, 1'b0, 1'b1));
      wr(2'd1, mx - 16'd1);
      ticks(1);
      chk("R4 reach max", count, mx);
      chk("R4 no flag at max", {15'd0, ovf}, 16'd0);
      ticks(1);
      chk("R4 wrap", count, 16'd0);
      chk("R4 flag on wrap", {15'd0, ovf}, 16'd1);
    end
  endtask

  task automatic t_divider;
    wr(2'd0, ctl(2'b10, 2'd3, 2'd2, 1'b1, 1'b0, 1'b1));
    ticks(8);  chk("R3 div4 8 ticks", count, 16'd2);
    idle(6);   chk("R3 no tick holds", count, 16'd2);
    ticks(3);  chk("R3 div4 partial", count, 16'd2);
    ticks(1);  chk("R3 div4 step", count, 16'd3);
    wr(2'd0, ctl(2'b10, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0));
    ticks(16); chk("R3 div8", count, 16'd2);
    wr(2'd0, ctl(2'b10, 2'd3, 2'd1, 1'b1, 1'b0, 1'b0));
    ticks(6);  chk("R3 div2", count, 16'd3);
  endtask

  task automatic t_up;
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(2'b01, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1));
    ticks(5);
    chk("R6 at compare", count, 16'd5);
    chk("R6 no flag yet", {15'd0, ovf}, 16'd0);
    ticks(1);
    chk("R6 wrap", count, 16'd0);
    chk("R6 flag", {15'd0, ovf}, 16'd1);
  endtask

  task automatic t_updown;
    logic [15:0] seq [6] = '{16'd1, 16'd2, 16'd3, 16'd2, 16'd1, 16'd0};
    wr(2'd2, 16'd3);
    wr(2'd0, ctl(2'b11, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1));
    for (int i = 0; i < 6; i++) begin
      ticks(1);
      chk("R7 sequence", count, seq[i]);
      chk("R7 flag only at down zero", {15'd0, ovf}, (i == 5) ? 16'd1 : 16'd0);
    end
    ticks(1);
    chk("R7 turn up", count, 16'd1);
  endtask

  task automatic t_cmp_zero;
    wr(2'd0, ctl(2'b01, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1));
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd0);
    ticks(3);
    chk("R8 up frozen", count, 16'd4);
    wr(2'd2, 16'd3);
    chk("R8 restart zero", count, 16'd0);
    ticks(2);
    chk("R8 counts after restart", count, 16'd2);
    wr(2'd0, ctl(2'b11, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0));
    ticks(4);
    chk("R8 updn falling", count, 16'd2);
    wr(2'd2, 16'd0);
    ticks(2);
    chk("R8 updn frozen", count, 16'd2);
    wr(2'd2, 16'd3);
    chk("R8 updn restart", count, 16'd0);
    ticks(1);
    chk("R8 restart direction up", count, 16'd1);
  endtask

  task automatic t_clear;
    wr(2'd0, ctl(2'b11, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1));
    ticks(9);
    chk("R9 setup falling", count, 16'd2);
    wr(2'd0, ctl(2'b11, 2'd3, 2'd1, 1'b1, 1'b0, 1'b0));
    chk("R9 count cleared", count, 16'd0);
    ticks(1);
    chk("R9 prescaler reset", count, 16'd0);
    ticks(1);
    chk("R9 direction up", count, 16'd1);
  endtask

  task automatic t_flag_irq;
    wr(2'd0, ctl(2'b01, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1));
    wr(2'd2, 16'd2);
    ticks(3);
    chk("R10 flag set", {15'd0, ovf}, 16'd1);
    chk("R10 irq masked", {15'd0, irq}, 16'd0);
    ticks(1);
    chk("R10 sticky", {15'd0, ovf}, 16'd1);
    wr(2'd0, ctl(2'b01, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0));
    chk("R10 irq enabled", {15'd0, irq}, 16'd1);
    wr(2'd0, ctl(2'b01, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1));
    chk("R10 flag w1c", {15'd0, ovf}, 16'd0);
    chk("R10 irq drops", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset_stop();
    t_load_mask();
    t_cont_lengths();
    t_divider();
    t_up();
    t_updown();
    t_cmp_zero();
    t_clear();
    t_flag_irq();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule